// File: doc/BRIEF.md
# Multiplexed External Memory Bridge

This block connects a core's 16-bit data-space bus to an external byte-wide parallel memory. The low address byte and the data byte share one 8-bit set of lines, the high address byte has its own lines, and an address-latch-enable output lets an outside latch capture the low byte before the same lines carry data. Active-low read and write strobes mark the data transfer. Addresses up to 0x21FF belong to on-chip storage. Addresses above that go to the external bus while the bridge is enabled.

The external range is split into a lower and an upper sector at a boundary that software sets on the high address byte. Each sector has its own 0–3 wait-state setting. For every external access the bridge holds the core with a stall output until the access completes. When the bridge stops driving the shared lines, an optional keeper holds the last value it drove. Software also chooses how many high address lines the bridge drives; the remaining lines are released.

Top module: `xmem_bridge`

## Requirements
- R1: An access at or below 0x21FF with the bridge enabled completes in its first cycle with no stall. `ale` is high for that one cycle, and `rd_n` and `wr_n` stay high.
- R2: An external access starts with one address cycle. In that cycle `ale` is high, `ad_oe` is high, `ad_o` carries address bits 7:0, `hi_addr` carries the high byte on the enabled lines, and both strobes are high.
- R3: In a read, `rd_n` is low for 1+W consecutive cycles starting in the cycle after the address cycle, where W is the sector's wait setting. `ad_oe` is low during that window. `core_rdata` equals `ad_i` in the last strobe cycle, which is the cycle where the stall drops.
- R4: In a write, `wr_n` is low for 1+W cycles starting in the cycle after the address cycle, and `ad_o` drives the write data with `ad_oe` high. If the next cycle carries no request, the data stays driven in that cycle while `wr_n` is high.
- R5: An external access holds `core_stall` high for exactly W+1 cycles: the address cycle and every strobe cycle except the last.
- R6: An address whose bits 15:8 are greater than or equal to `cfg_split` uses `cfg_wait_hi`. Any other external address uses `cfg_wait_lo`.
- R7: While `ad_oe` is low and `cfg_keep` is 1, `ad_keep` is 1 and `ad_o` holds the last value the bridge drove. While `ad_oe` is low and `cfg_keep` is 0, `ad_keep` is 0 and `ad_o` is zero.
- R8: `hi_oe[i]` is 1 exactly when the bridge is enabled and i < `cfg_hi_cnt`. A count of 8 or more enables all eight lines. `hi_addr` is zero on every line that is not enabled.
- R9: With `cfg_en` low, no access raises `ale`, `ad_oe`, `hi_oe` or `core_stall`, and no access pulls a strobe low. A read above 0x21FF then returns zero.
- R10: During reset `ale` is low, both strobes are high, `ad_oe` is low and `core_stall` is low.
- R11: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Bridge enable |
| cfg_keep | input | 1 | Keeper enable for the shared lines |
| cfg_split | input | 8 | High-byte boundary; at or above it is the upper sector |
| cfg_wait_lo | input | 2 | Wait states for the lower sector |
| cfg_wait_hi | input | 2 | Wait states for the upper sector |
| cfg_hi_cnt | input | 4 | Number of high address lines driven |
| core_req | input | 1 | Access request; held until the stall drops |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Data-space address |
| core_wdata | input | 8 | Write data |
| core_rdata | output | 8 | Read data; valid in the completing cycle of an external read |
| core_stall | output | 1 | Holds the core while an external access is in progress |
| ad_o | output | 8 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared lines, incoming value |
| ad_keep | output | 1 | Keeper active on the shared lines |
| hi_addr | output | 8 | High address byte |
| hi_oe | output | 8 | Per-line drive enable for the high address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong wait count or a wrong sector choice shows up in the same access as a stall or strobe window of the wrong length. That error is visible at the latest four cycles after the address cycle. A stale direction flag shows as a strobe of the wrong type, or as `ad_oe` held high under a read strobe, in the first cycle after `ale`. A wrong keeper register shows as a changed `ad_o` in the first released cycle. A state that does not return to idle stalls the next access or pulls a strobe low on an internal access.

// File: rtl/xmem_bridge.sv
module xmem_bridge #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int WAIT_W = 2,
  parameter int unsigned INT_TOP = 'h21FF,
  localparam int HW = AW - DW,
  localparam int CW = $clog2(HW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_keep,
  input  logic [HW-1:0]     cfg_split,
  input  logic [WAIT_W-1:0] cfg_wait_lo,
  input  logic [WAIT_W-1:0] cfg_wait_hi,
  input  logic [CW-1:0]     cfg_hi_cnt,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [AW-1:0]     core_addr,
  input  logic [DW-1:0]     core_wdata,
  output logic [DW-1:0]     core_rdata,
  output logic              core_stall,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_i,
  output logic              ad_keep,
  output logic [HW-1:0]     hi_addr,
  output logic [HW-1:0]     hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  localparam logic [AW-1:0] TOP = INT_TOP[AW-1:0];

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD} st_t;

  st_t               st;
  logic [WAIT_W-1:0] cnt;
  logic [HW-1:0]     ah_q;
  logic              we_q;
  logic [DW-1:0]     wd_q;
  logic [DW-1:0]     last_q;

  logic              free, ext_hit, go_ext, go_int, addr_ph;
  logic              in_strb, last_beat, upper;
  logic [WAIT_W-1:0] wsel;
  logic [DW-1:0]     drive_val;
  logic [HW-1:0]     cur_hi;

  assign free      = (st != S_STRB);
  assign ext_hit   = core_addr > TOP;
  assign go_ext    = cfg_en & core_req & free & ext_hit;
  assign go_int    = cfg_en & core_req & free & ~ext_hit;
  assign addr_ph   = go_ext | go_int;
  assign upper     = core_addr[AW-1:DW] >= cfg_split;
  assign wsel      = upper ? cfg_wait_hi : cfg_wait_lo;
  assign in_strb   = (st == S_STRB);
  assign last_beat = in_strb & (cnt == '0);

  assign drive_val  = addr_ph ? core_addr[DW-1:0] : wd_q;
  assign ad_oe      = cfg_en & (addr_ph | (in_strb & we_q) | ((st == S_HOLD) & ~addr_ph));
  assign ad_o       = ad_oe ? drive_val : (cfg_keep ? last_q : '0);
  assign ad_keep    = cfg_keep & ~ad_oe;
  assign ale        = addr_ph;
  assign rd_n       = ~(in_strb & ~we_q);
  assign wr_n       = ~(in_strb & we_q);
  assign core_stall = go_ext | (in_strb & (cnt != '0));
  assign core_rdata = (last_beat & ~we_q) ? ad_i : '0;
  assign cur_hi     = addr_ph ? core_addr[AW-1:DW] : ah_q;

  for (genvar i = 0; i < HW; i++) begin : g_hi
    assign hi_oe[i]   = cfg_en & (cfg_hi_cnt > CW'(i));
    assign hi_addr[i] = hi_oe[i] & cur_hi[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ah_q   <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      last_q <= '0;
    end else begin
      if (ad_oe) last_q <= drive_val;
      unique case (st)
        S_STRB: begin
          if (cnt == '0) st <= we_q ? S_HOLD : S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: begin
          if (go_ext) begin
            st   <= S_STRB;
            cnt  <= wsel;
            ah_q <= core_addr[AW-1:DW];
            we_q <= core_we;
            wd_q <= core_wdata;
          end else begin
            st <= S_IDLE;
            if (go_int) ah_q <= core_addr[AW-1:DW];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_keep,
  input logic          core_stall,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ad_oe,
  input logic [DW-1:0] ad_o
);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R11
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R3
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && core_stall) |=> (!rd_n || !wr_n));

  // R1
  int_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !core_stall) |=> (rd_n && wr_n));

  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R7
  keeper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_keep && $stable(cfg_keep) && !ad_oe && $past(ad_oe)) |-> (ad_o == $past(ad_o)));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!ale && !core_stall && rd_n && wr_n && !ad_oe));

endmodule

bind xmem_bridge xmem_bridge_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_keep(cfg_keep),
  .core_stall(core_stall), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .ad_o(ad_o)
);

// File: tb/xmem_bridge_bench.sv
module xmem_bridge_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cfg_en = 1'b1, cfg_keep = 1'b1;
  logic [7:0] cfg_split = 8'h80;
  logic [1:0] cfg_wait_lo = 2'd0, cfg_wait_hi = 2'd0;
  logic [3:0] cfg_hi_cnt = 4'd8;
  logic       core_req = 1'b0, core_we = 1'b0;
  logic [15:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic [7:0] core_rdata, ad_o, ad_i, hi_addr, hi_oe;
  logic       core_stall, ad_oe, ad_keep, ale, rd_n, wr_n;

  xmem_bridge u_xmem_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_keep(cfg_keep),
    .cfg_split(cfg_split), .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
    .cfg_hi_cnt(cfg_hi_cnt), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_stall(core_stall), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .ad_keep(ad_keep), .hi_addr(hi_addr), .hi_oe(hi_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  logic [7:0] ext_mem [0:65535];
  logic [7:0] ref_mem [0:65535];
  logic [7:0] lat_lo = '0;

  always @(negedge clk) if (ale) lat_lo = ad_o;
  always @(negedge clk) if (!wr_n) ext_mem[{hi_addr, lat_lo}] = ad_o;
  assign ad_i = !rd_n ? ext_mem[{hi_addr, lat_lo}] : 8'h00;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [7:0]  wd;
    int          stall;
    int          strb;
    logic [7:0]  rd;
    int          ale_n;
    logic [7:0]  hi;
  } exp_t;

  exp_t q[$];

  function automatic logic [7:0] hi_mask();
    return (cfg_hi_cnt >= 4'd8) ? 8'hFF : 8'((1 << cfg_hi_cnt) - 1);
  endfunction

  task automatic access(input logic [15:0] addr, input logic we, input logic [7:0] wd);
    exp_t e;
    int w;
    logic [15:0] pa;
    pa = {addr[15:8] & hi_mask(), addr[7:0]};
    e.addr = addr; e.we = we; e.wd = wd; e.hi = addr[15:8] & hi_mask();
    e.rd = 8'h00;
    if (!cfg_en) begin
      e.stall = 0; e.strb = 0; e.ale_n = 0;
    end else if (addr <= 16'h21FF) begin
      e.stall = 0; e.strb = 0; e.ale_n = 1;
    end else begin
      w = (addr[15:8] >= cfg_split) ? int'(cfg_wait_hi) : int'(cfg_wait_lo);
      e.stall = w + 1; e.strb = w + 1; e.ale_n = 1;
      if (we) ref_mem[pa] = wd;
      else    e.rd = ref_mem[pa];
    end
    q.push_back(e);
    @(posedge clk); #1;
    core_req = 1'b1; core_we = we; core_addr = addr; core_wdata = wd;
    do @(negedge clk); while (core_stall);
    @(posedge clk); #1;
    core_req = 1'b0;
  endtask

  // scoreboard monitor
  bit busy = 0, hold_chk = 0;
  int s_cnt = 0, st_cnt = 0, a_cnt = 0;
  logic [7:0] hold_val = '0;
  exp_t cur;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_chk && !core_req)
        chk(ad_oe && ad_o == hold_val && wr_n, "R4 data held after strobe", ad_o, hold_val);
      hold_chk = 0;
      if (!rd_n || !wr_n)
        chk(!(!rd_n && !wr_n) && !ale, "R11 strobe exclusivity", {rd_n, wr_n, ale}, 3'b100);
      if (core_req && q.size() > 0) begin
        if (!busy) begin busy = 1; s_cnt = 0; st_cnt = 0; a_cnt = 0; end
        cur = q[0];
        if (ale) begin
          a_cnt++;
          chk(ad_oe && ad_o == cur.addr[7:0] && rd_n && wr_n, "R2 address cycle", ad_o, cur.addr[7:0]);
          chk(hi_addr == cur.hi, "R8 high address lines", hi_addr, cur.hi);
        end
        if (core_stall) s_cnt++;
        if (!rd_n) begin
          st_cnt++;
          chk(!ad_oe && ad_keep == cfg_keep && ad_o == (cfg_keep ? cur.addr[7:0] : 8'h00),
              "R7 keeper under read", ad_o, cfg_keep ? cur.addr[7:0] : 8'h00);
        end
        if (!wr_n) begin
          st_cnt++;
          chk(ad_oe && ad_o == cur.wd, "R4 write data driven", ad_o, cur.wd);
        end
        if (!core_stall) begin
          void'(q.pop_front());
          busy = 0;
          chk(s_cnt == cur.stall, "R5 R6 stall length", s_cnt, cur.stall);
          chk(st_cnt == cur.strb, cur.we ? "R4 write strobe width" : "R3 read strobe width", st_cnt, cur.strb);
          chk(a_cnt == cur.ale_n, cfg_en ? "R1 latch enable count" : "R9 no latch enable", a_cnt, cur.ale_n);
          if (!cur.we) chk(core_rdata == cur.rd, cfg_en ? "R3 read data" : "R9 read zero", core_rdata, cur.rd);
          if (cur.we && cur.strb > 0) begin hold_chk = 1; hold_val = cur.wd; end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 65536; i++) begin
      ext_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe && !core_stall, "R10 reset state",
        {ale, rd_n, wr_n, ad_oe, core_stall}, 5'b01100);
    @(posedge clk); #1 rst_n = 1'b1;

    // internal region
    access(16'h0100, 1'b1, 8'h5A);
    access(16'h21FF, 1'b0, 8'h00);
    // first external address
    access(16'h2200, 1'b1, 8'hC3);
    access(16'h2200, 1'b0, 8'h00);

    // every wait setting in both sectors
    for (int lo = 0; lo < 4; lo++) begin
      for (int hi = 0; hi < 4; hi++) begin
        @(posedge clk); #1 cfg_wait_lo = 2'(lo); cfg_wait_hi = 2'(hi);
        access(16'h3000 + 16'(lo * 16 + hi), 1'b1, 8'(lo * 40 + hi + 1));
        access(16'h3000 + 16'(lo * 16 + hi), 1'b0, 8'h00);
        access(16'h9000 + 16'(lo * 16 + hi), 1'b1, 8'(hi * 40 + lo + 9));
        access(16'h9000 + 16'(lo * 16 + hi), 1'b0, 8'h00);
      end
    end

    // R6 boundary on both sides
    @(posedge clk); #1 cfg_wait_lo = 2'd1; cfg_wait_hi = 2'd3;
    access(16'h7FFF, 1'b0, 8'h00);
    access(16'h8000, 1'b0, 8'h00);
    @(posedge clk); #1 cfg_split = 8'h00;
    access(16'h2300, 1'b0, 8'h00);
    @(posedge clk); #1 cfg_split = 8'hFF;
    access(16'hFEFF, 1'b0, 8'h00);
    access(16'hFF00, 1'b0, 8'h00);

    // R7 keeper off
    @(posedge clk); #1 cfg_keep = 1'b0;
    access(16'h4000, 1'b0, 8'h00);
    @(posedge clk); #1 cfg_keep = 1'b1;

    // R8 high address line count
    @(posedge clk); #1 cfg_hi_cnt = 4'd4;
    @(negedge clk);
    chk(hi_oe == 8'h0F, "R8 four lines enabled", hi_oe, 8'h0F);
    access(16'hA345, 1'b1, 8'h77);
    access(16'hA345, 1'b0, 8'h00);
    @(posedge clk); #1 cfg_hi_cnt = 4'd12;
    @(negedge clk);
    chk(hi_oe == 8'hFF, "R8 count above width", hi_oe, 8'hFF);
    @(posedge clk); #1 cfg_hi_cnt = 4'd8;

    // R9 disabled
    @(posedge clk); #1 cfg_en = 1'b0;
    @(negedge clk);
    chk(hi_oe == 8'h00 && !ad_oe, "R9 lines released", hi_oe, 8'h00);
    access(16'h5000, 1'b0, 8'h00);
    access(16'h0100, 1'b1, 8'h11);
    @(posedge clk); #1 cfg_en = 1'b1;
    access(16'h5000, 1'b0, 8'h00);

    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule